// File: doc/BRIEF.md
# Resident Block Limit Calculator

This block works out how many thread blocks one multiprocessor can hold at the same time. A request gives three numbers for a kernel launch: threads per block, registers per thread and shared-memory bytes per block. Four configuration inputs describe the multiprocessor: the hardware cap on resident blocks, the thread pool, the register pool and the shared-memory pool. Each request is first rounded up to the granularity at which the hardware hands out that resource. The pool is then divided by the rounded request. The result is the smallest of the four bounds, together with a code that names the bound that set it.

The block also reports the occupancy: the resident warp count, and that count as a whole percentage of the warp capacity of the thread pool. It flags a launch as invalid when a single block already needs more than a whole pool. All divisions share one bit-serial divider, so a result takes about a hundred cycles.

Requests enter over a valid/ready pair. The request fields and the configuration inputs are sampled only in the accepting cycle. The input stays not-ready until the result has been taken. The result is offered over a second valid/ready pair and is held unchanged while the consumer applies back-pressure.

Top module: `occ_calc`

## Requirements
- R1: The resident block count `res_blocks` is the minimum of the configured block cap, the thread bound, the register bound and the shared-memory bound, and never exceeds the cap.
- R2: Threads per block are rounded up to a whole multiple of 32. The thread bound is floor(thread pool / rounded threads), so a request for 50 threads costs 64.
- R3: The register request is the registers per thread times the rounded thread count, rounded up to a multiple of 256. The register bound is floor(register pool / rounded request). A request of zero registers leaves the register bound unlimited.
- R4: The shared-memory request is rounded up to a multiple of 128 bytes. The shared-memory bound is floor(pool / rounded request). A request of zero bytes leaves the bound unlimited.
- R5: `res_limit` names the binding bound with the codes 0 = block cap, 1 = threads, 2 = registers, 3 = shared memory. When bounds tie, the lowest code is reported.
- R6: A launch is invalid when the thread count is zero or exceeds the thread pool after rounding, when the rounded register request exceeds the register pool, or when the rounded shared-memory request exceeds the shared-memory pool. An invalid launch gives `res_bad`=1, zero blocks, zero warps and zero occupancy. `res_limit` then holds the first failing pool in the order threads (1), registers (2), shared memory (3).
- R7: `res_warps` is the block count times the warps per block. `res_occ` is floor(100 × `res_warps` / (thread pool / 32)) and is at most 100.
- R8: `req_ready` is high only while no request is in progress and no result is pending. A result with `res_valid` high keeps all result fields stable until `res_ready` is seen. Request and configuration inputs that change while not ready have no effect.
- R9: After reset `req_ready` is 1 and `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_blk_cap | input | CW | Hardware cap on resident blocks |
| cfg_thr_pool | input | TW | Threads available on the multiprocessor |
| cfg_reg_pool | input | PW | Registers available on the multiprocessor |
| cfg_smem_pool | input | SW | Shared-memory bytes available |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_threads | input | TW | Threads per block |
| req_regs | input | RW | Registers per thread |
| req_smem | input | SW | Shared-memory bytes per block |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Consumer takes the result |
| res_blocks | output | CW | Resident block count |
| res_limit | output | 2 | Binding bound code |
| res_bad | output | 1 | Launch invalid |
| res_warps | output | CW+TW+1-5 | Resident warps |
| res_occ | output | 7 | Occupancy in whole percent |

## Verification
A table of launches is run in which each bound in turn is made the smallest one: cap-bound, thread-bound, register-bound and shared-memory-bound cases. This shows that the minimum and the limit code follow the right resource. Pairs such as 6144 and 6145 shared-memory bytes, 50 threads against a 64-thread cost, and a register request exactly equal to the pool separate correct rounding from plain division. They also separate a strict over-pool test from a non-strict one. Tie rows with equal bounds fix the code priority, and one invalid row per pool plus a zero-thread row check the failure order. A directed test stalls a finished result under back-pressure while a different request is offered, and checks that neither the result nor the following computation is disturbed.

// File: rtl/occ_pkg.sv
package occ_pkg;
  typedef enum logic [1:0] {
    LIM_CAP  = 2'd0,
    LIM_THR  = 2'd1,
    LIM_REG  = 2'd2,
    LIM_SMEM = 2'd3
  } lim_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_DTHR, S_DREG, S_DSMEM, S_PICK, S_DOCC, S_DONE
  } st_e;
endpackage

// File: rtl/occ_round.sv
module occ_round #(
  parameter int W  = 12,
  parameter int LG = 5
) (
  input  logic [W-1:0] din,
  output logic [W:0]   dout
);
  localparam logic [W:0] MASK = (W+1)'((1 << LG) - 1);
  logic [W:0] sum;
  always_comb begin
    sum  = {1'b0, din} + MASK;
    dout = sum & ~MASK;
  end
endmodule

// File: rtl/occ_div.sv
module occ_div #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [DW-1:0] quo
);
  localparam int CNTW = $clog2(DW + 1);

  logic [DW-1:0] rem, n_q, d_q;
  logic [CNTW-1:0] cnt;
  logic busy;
  logic [DW:0] rem_sh, diff;
  logic ge;
  logic unused_diff_top;

  always_comb begin
    rem_sh = {rem, quo[DW-1]};
    diff   = rem_sh - {1'b0, d_q};
    ge     = rem_sh >= {1'b0, d_q};
    unused_diff_top = diff[DW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem <= '0; quo <= '0; n_q <= '0; d_q <= '0;
      cnt <= '0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem <= '0; quo <= num; n_q <= num; d_q <= den;
        cnt <= CNTW'(DW); busy <= 1'b1;
      end else if (busy) begin
        rem <= ge ? diff[DW-1:0] : rem_sh[DW-1:0];
        quo <= {quo[DW-2:0], ge};
        cnt <= cnt - 1'b1;
        if (cnt == CNTW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // floor division underlies the bounds of R2, R3, R4 and R7
  assert_div_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((2*DW)'(quo) * (2*DW)'(d_q) <= (2*DW)'(n_q)) &&
             ((2*DW)'(n_q) - (2*DW)'(quo) * (2*DW)'(d_q) < (2*DW)'(d_q)));
endmodule

// File: rtl/occ_pick.sv
module occ_pick
  import occ_pkg::*;
#(
  parameter int CW = 6,
  parameter int DW = 24
) (
  input  logic [CW-1:0] cap,
  input  logic [DW-1:0] lim_thr,
  input  logic [DW-1:0] lim_reg,
  input  logic [DW-1:0] lim_smem,
  output logic [CW-1:0] blocks,
  output lim_e          code
);
  logic [DW-1:0] best;
  logic unused_best_hi;
  always_comb begin
    best = DW'(cap);
    code = LIM_CAP;
    // strict compares keep the earlier code on a tie (R5)
    if (lim_thr < best)  begin best = lim_thr;  code = LIM_THR;  end
    if (lim_reg < best)  begin best = lim_reg;  code = LIM_REG;  end
    if (lim_smem < best) begin best = lim_smem; code = LIM_SMEM; end
    blocks = best[CW-1:0];
    unused_best_hi = ^best[DW-1:CW];
  end
endmodule

// File: rtl/occ_calc.sv
module occ_calc
  import occ_pkg::*;
#(
  parameter int TW           = 12,
  parameter int RW           = 8,
  parameter int PW           = 17,
  parameter int SW           = 17,
  parameter int CW           = 6,
  parameter int WARP_LG      = 5,
  parameter int REG_PAGE_LG  = 8,
  parameter int SMEM_PAGE_LG = 7,
  parameter int OCC_W        = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CW-1:0]             cfg_blk_cap,
  input  logic [TW-1:0]             cfg_thr_pool,
  input  logic [PW-1:0]             cfg_reg_pool,
  input  logic [SW-1:0]             cfg_smem_pool,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [TW-1:0]             req_threads,
  input  logic [RW-1:0]             req_regs,
  input  logic [SW-1:0]             req_smem,
  output logic                      res_valid,
  input  logic                      res_ready,
  output logic [CW-1:0]             res_blocks,
  output logic [1:0]                res_limit,
  output logic                      res_bad,
  output logic [CW+TW-WARP_LG:0]    res_warps,
  output logic [OCC_W-1:0]          res_occ
);
  localparam int DW  = TW + RW + 4;
  localparam int WW  = CW + TW + 1 - WARP_LG;
  localparam int WPB = TW + 1 - WARP_LG;
  localparam int RQW = TW + RW + 1;

  st_e st;
  logic [CW-1:0] cap_q;
  logic [TW-1:0] tpool_q, thr_q;
  logic [PW-1:0] rpool_q;
  logic [SW-1:0] spool_q, smem_q;
  logic [RW-1:0] regs_q;

  logic [TW:0]   thr_rnd;
  logic [RQW-1:0] reg_raw;
  logic [RQW:0]  reg_rnd;
  logic [SW:0]   smem_rnd;

  occ_round #(.W(TW),  .LG(WARP_LG))      u_rthr (.din(thr_q),   .dout(thr_rnd));
  occ_round #(.W(RQW), .LG(REG_PAGE_LG))  u_rreg (.din(reg_raw), .dout(reg_rnd));
  occ_round #(.W(SW),  .LG(SMEM_PAGE_LG)) u_rsm  (.din(smem_q),  .dout(smem_rnd));

  logic bad_thr, bad_reg, bad_smem;
  logic [WPB-1:0] wpb;
  logic [TW-WARP_LG-1:0] warp_max;
  always_comb begin
    reg_raw  = RQW'(thr_rnd) * RQW'(regs_q);
    bad_thr  = (thr_q == '0) || (thr_rnd > {1'b0, tpool_q});
    bad_reg  = DW'(reg_rnd) > DW'(rpool_q);
    bad_smem = DW'(smem_rnd) > DW'(spool_q);
    wpb      = thr_rnd[TW:WARP_LG];
    warp_max = tpool_q[TW-1:WARP_LG];
  end

  logic [DW-1:0] lim_thr, lim_reg, lim_smem;
  logic [CW-1:0] pick_blocks;
  lim_e          pick_code;
  logic [WW-1:0] act_warps;

  occ_pick #(.CW(CW), .DW(DW)) u_pick (
    .cap(cap_q), .lim_thr(lim_thr), .lim_reg(lim_reg), .lim_smem(lim_smem),
    .blocks(pick_blocks), .code(pick_code));

  always_comb act_warps = WW'(pick_blocks) * WW'(wpb);

  logic          div_go, div_done;
  logic [DW-1:0] div_n, div_d, div_q;
  logic          unused_occ_hi;
  always_comb unused_occ_hi = ^div_q[DW-1:OCC_W];

  occ_div #(.DW(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_n), .den(div_d),
    .done(div_done), .quo(div_q));

  lim_e res_code;
  assign req_ready = (st == S_IDLE);
  assign res_valid = (st == S_DONE);
  assign res_limit = res_code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cap_q <= '0; tpool_q <= '0; rpool_q <= '0; spool_q <= '0;
      thr_q <= '0; regs_q <= '0; smem_q <= '0;
      lim_thr <= '0; lim_reg <= '0; lim_smem <= '0;
      div_go <= 1'b0; div_n <= '0; div_d <= '0;
      res_blocks <= '0; res_code <= LIM_CAP; res_bad <= 1'b0;
      res_warps <= '0; res_occ <= '0;
    end else begin
      div_go <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          cap_q <= cfg_blk_cap; tpool_q <= cfg_thr_pool;
          rpool_q <= cfg_reg_pool; spool_q <= cfg_smem_pool;
          thr_q <= req_threads; regs_q <= req_regs; smem_q <= req_smem;
          st <= S_CHECK;
        end
        S_CHECK: begin
          if (bad_thr || bad_reg || bad_smem) begin
            res_bad <= 1'b1; res_blocks <= '0; res_warps <= '0; res_occ <= '0;
            res_code <= bad_thr ? LIM_THR : (bad_reg ? LIM_REG : LIM_SMEM);
            st <= S_DONE;
          end else begin
            res_bad <= 1'b0;
            div_go <= 1'b1; div_n <= DW'(tpool_q); div_d <= DW'(thr_rnd);
            st <= S_DTHR;
          end
        end
        S_DTHR: if (div_done) begin
          lim_thr <= div_q;
          if (reg_rnd == '0) begin
            lim_reg <= '1;
            if (smem_rnd == '0) begin lim_smem <= '1; st <= S_PICK; end
            else begin
              div_go <= 1'b1; div_n <= DW'(spool_q); div_d <= DW'(smem_rnd);
              st <= S_DSMEM;
            end
          end else begin
            div_go <= 1'b1; div_n <= DW'(rpool_q); div_d <= DW'(reg_rnd);
            st <= S_DREG;
          end
        end
        S_DREG: if (div_done) begin
          lim_reg <= div_q;
          if (smem_rnd == '0) begin lim_smem <= '1; st <= S_PICK; end
          else begin
            div_go <= 1'b1; div_n <= DW'(spool_q); div_d <= DW'(smem_rnd);
            st <= S_DSMEM;
          end
        end
        S_DSMEM: if (div_done) begin
          lim_smem <= div_q;
          st <= S_PICK;
        end
        S_PICK: begin
          res_blocks <= pick_blocks;
          res_code   <= pick_code;
          res_warps  <= act_warps;
          div_go <= 1'b1;
          div_n  <= DW'(act_warps) * DW'(100);
          div_d  <= DW'(warp_max);
          st <= S_DOCC;
        end
        S_DOCC: if (div_done) begin
          res_occ <= div_q[OCC_W-1:0];
          st <= S_DONE;
        end
        S_DONE: if (res_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_blocks) && $stable(res_limit)
      && $stable(res_bad) && $stable(res_warps) && $stable(res_occ));

  assert_accept_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready && !res_valid);

  assert_under_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_blocks <= cap_q);

  assert_bad_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_bad |-> res_blocks == '0 && res_warps == '0 && res_occ == '0);

  assert_occ_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_occ <= OCC_W'(100));
endmodule

// File: tb/occ_calc_test.sv
module occ_calc_test;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 12, RW = 8, PW = 17, SW = 17, CW = 6, OCC_W = 7;
  localparam int WD_LIMIT = 100000;
  localparam int NV = 14;
  // cap, thr_pool, reg_pool, smem_pool, threads, regs, smem,
  // exp blocks, exp code, exp bad, exp warps, exp occ
  localparam int VEC [NV][12] = '{
    '{16, 2048, 32768, 49152,  128, 16,     0, 16, 0, 0, 64, 100},
    '{16, 2048, 32768, 49152,  256, 16,     0,  8, 1, 0, 64, 100},
    '{16, 2048, 32768, 49152,   64, 16,     0, 16, 0, 0, 32,  50},
    '{ 8, 1536, 32768, 49152,   50, 20,  1000,  8, 0, 0, 16,  33},
    '{ 8, 1536, 32768, 16384,  128, 10,  6000,  2, 3, 0,  8,  16},
    '{ 8, 1536,  8192, 49152,  256, 20,     0,  1, 2, 0,  8,  16},
    '{ 8, 1536, 32768, 49152,   32,  1,  6144,  8, 0, 0,  8,  16},
    '{ 8, 1536, 32768, 49152,   32,  1,  6145,  7, 3, 0,  7,  14},
    '{ 8, 1536, 32768, 49152, 2000,  1,     0,  0, 1, 1,  0,   0},
    '{ 8, 1536,  8192, 49152,  512, 20,     0,  0, 2, 1,  0,   0},
    '{ 8, 1536, 32768, 16384,   64,  1, 16385,  0, 3, 1,  0,   0},
    '{ 8, 1536, 32768, 49152,    0, 10,     0,  0, 1, 1,  0,   0},
    '{16, 2048, 32768, 49152, 1024, 32,     0,  1, 2, 0, 32,  50},
    '{ 8, 1536, 32768, 49152,   96,  0,     0,  8, 0, 0, 24,  50}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] cfg_blk_cap = '0;
  logic [TW-1:0] cfg_thr_pool = '0, req_threads = '0;
  logic [PW-1:0] cfg_reg_pool = '0;
  logic [SW-1:0] cfg_smem_pool = '0, req_smem = '0;
  logic [RW-1:0] req_regs = '0;
  logic req_valid = 1'b0, res_ready = 1'b0;
  logic req_ready, res_valid, res_bad;
  logic [CW-1:0] res_blocks;
  logic [1:0] res_limit;
  logic [CW+TW-5:0] res_warps;
  logic [OCC_W-1:0] res_occ;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  occ_calc uut (
    .clk(clk), .rst_n(rst_n), .cfg_blk_cap(cfg_blk_cap), .cfg_thr_pool(cfg_thr_pool),
    .cfg_reg_pool(cfg_reg_pool), .cfg_smem_pool(cfg_smem_pool),
    .req_valid(req_valid), .req_ready(req_ready), .req_threads(req_threads),
    .req_regs(req_regs), .req_smem(req_smem), .res_valid(res_valid),
    .res_ready(res_ready), .res_blocks(res_blocks), .res_limit(res_limit),
    .res_bad(res_bad), .res_warps(res_warps), .res_occ(res_occ));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog: got %0d cycles expected fewer than %0d", cyc, WD_LIMIT);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string row_tag(input int i);
    case (i)
      1: return "R5 tie threads/regs";
      3: return "R2 warp rounding";
      4, 6, 7: return "R4 smem page";
      5, 12, 13: return "R3 register bound";
      8, 9, 10, 11: return "R6 invalid launch";
      default: return "R1 minimum";
    endcase
  endfunction

  task automatic load_row(input int i);
    cfg_blk_cap   = CW'(VEC[i][0]);
    cfg_thr_pool  = TW'(VEC[i][1]);
    cfg_reg_pool  = PW'(VEC[i][2]);
    cfg_smem_pool = SW'(VEC[i][3]);
    req_threads   = TW'(VEC[i][4]);
    req_regs      = RW'(VEC[i][5]);
    req_smem      = SW'(VEC[i][6]);
  endtask

  task automatic send_and_wait();
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
  endtask

  task automatic take();
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  task automatic check_row(input int i);
    string t;
    t = row_tag(i);
    chk({t, " R1 blocks"}, int'(res_blocks), VEC[i][7]);
    chk({t, " R5 limit code"}, int'(res_limit), VEC[i][8]);
    chk({t, " R6 bad flag"}, int'(res_bad), VEC[i][9]);
    chk({t, " R7 warps"}, int'(res_warps), VEC[i][10]);
    chk({t, " R7 occupancy"}, int'(res_occ), VEC[i][11]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 req_ready after reset", int'(req_ready), 1);
    chk("R9 res_valid after reset", int'(res_valid), 0);

    for (int i = 0; i < NV; i++) begin
      load_row(i);
      send_and_wait();
      check_row(i);
      take();
    end

    // R8: stall a result, offer a different request meanwhile
    load_row(4);
    send_and_wait();
    load_row(0);
    req_valid = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 result held valid", int'(res_valid), 1);
    chk("R8 req_ready low while pending", int'(req_ready), 0);
    check_row(4);
    req_valid = 1'b0;
    take();
    chk("R8 released after take", int'(res_valid), 0);
    // the stalled request was not taken: a fresh one still computes correctly
    load_row(7);
    send_and_wait();
    check_row(7);
    take();

    // R8: config inputs changed mid-computation have no effect
    load_row(5);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cfg_reg_pool = PW'(65535);
    cfg_blk_cap  = CW'(1);
    while (!res_valid) @(negedge clk);
    check_row(5);
    take();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule